// File: doc/BRIEF.md
# Up-the-Ramp Slope Estimator

This block turns a stream of non-destructive reads of one pixel into a signal-rate estimate. A ramp is the set of reads taken during one exposure. The reads are equally spaced in time and their spacing is known in advance, so the least-squares line through them reduces to a closed form. That form needs only two running sums: S0, the sum of the read values, and S1, the sum of each value weighted by its read index. The sums of the time terms are constants and are never accumulated.

A ramp opens on `start_i`, which also captures the programmed read count n and a reciprocal constant. Each `sample_valid_i` strobe adds one read to the sums. `end_i` closes the ramp and starts a short pipeline. The pipeline forms the numerator `12*S1 - 6*(n+1)*S0`. It then multiplies that numerator once by the reciprocal, which the caller computes in advance as 2^FRAC_W / (n*(n^2-1)*dt). Both the raw numerator and the scaled slope are reported, together with a one-cycle valid pulse and an error flag.

Top module: `ramp_slope_fit`

## Requirements
- R1: After reset, `valid_o` and `err_o` are low, and `slope_num_o` and `slope_o` are zero.
- R2: `start_i` clears both sums and the read index, and captures `num_reads_i` and `recip_i`. A sample that is valid in the same cycle becomes read 1. A start that arrives while a ramp is open discards that ramp.
- R3: The numerator is `12*S1 - 6*(n+1)*S0`, where S0 is the sum of the accepted unsigned samples Vi and S1 is the sum of i*Vi. The index i counts accepted reads from 1. The numerator is reported as a two's-complement value of NUM_W bits. Idle cycles between samples are allowed, and a sample that coincides with `end_i` is included.
- R4: `slope_o` equals floor(numerator * recip / 2^FRAC_W), where recip is the unsigned constant captured at start.
- R5: `end_i` during an open ramp closes it. `valid_o` is then high for exactly one cycle, following the second rising edge after the edge that sampled `end_i`. All outputs hold their values between results.
- R6: If n < 2 or n > MAX_READS, the result has `err_o` high, and both `slope_num_o` and `slope_o` are zero.
- R7: If fewer reads than n were accepted, `err_o` is high. The numerator is still formed from the accepted reads using the programmed n.
- R8: Samples that arrive after n reads have been accepted are left out of the sums and set `err_o` for that ramp.
- R9: Samples and `end_i` that arrive while no ramp is open produce no result and do not change the next ramp's result.
- R10: With SAMPLE_W-bit samples at full scale and n = MAX_READS, the sums and the numerator are exact and do not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a ramp, clears the sums, and captures n and the reciprocal |
| end_i | input | 1 | Closes the open ramp and requests a result |
| sample_valid_i | input | 1 | Marks `sample_i` as one read |
| sample_i | input | SAMPLE_W | Read value, unsigned |
| num_reads_i | input | CNT_W | Programmed read count n |
| recip_i | input | RECIP_W | Reciprocal of the fit denominator, with FRAC_W fraction bits |
| valid_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | The result belongs to a malformed ramp |
| slope_num_o | output | NUM_W | Signed slope numerator |
| slope_o | output | NUM_W | Signed scaled slope |

## Verification
The bench builds the block with its default parameters: 16-bit samples, up to 256 reads, and a 24-bit reciprocal with 24 fraction bits. These values make it possible to run a full 256-read ramp at full scale, both flat and steeply falling, which exercises the widest sums and the most negative numerator. They also bring the bounds on n into range: the lower limit, the upper limit and a value past it, as well as short and overlong ramps. With a 24-bit fraction, rounding the reciprocal up yields integer slopes, so the floor behaviour can be checked on both signs.

// File: rtl/ramp_fit_pkg.sv
package ramp_fit_pkg;
  localparam int unsigned MIN_READS = 2;
  localparam int unsigned S1_WEIGHT = 12;
  localparam int unsigned S0_WEIGHT = 6;
endpackage

// File: rtl/ramp_accum.sv
module ramp_accum #(
  parameter int SAMPLE_W  = 16,
  parameter int MAX_READS = 256,
  parameter int RECIP_W   = 24,
  parameter int CNT_W     = 9,
  parameter int S0_W      = 25,
  parameter int S1_W      = 34
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                end_i,
  input  logic                sample_valid_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [CNT_W-1:0]    num_reads_i,
  input  logic [RECIP_W-1:0]  recip_i,
  output logic                done_o,
  output logic [S0_W-1:0]     s0_o,
  output logic [S1_W-1:0]     s1_o,
  output logic [CNT_W-1:0]    n_o,
  output logic [CNT_W-1:0]    cnt_o,
  output logic                over_o,
  output logic [RECIP_W-1:0]  recip_o
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_READS);

  logic               active_q, done_q, over_q;
  logic [CNT_W-1:0]   n_q, idx_q;
  logic [S0_W-1:0]    s0_q;
  logic [S1_W-1:0]    s1_q;
  logic [RECIP_W-1:0] recip_q;

  logic               live, take, accept, close_ramp, over_cur;
  logic [CNT_W-1:0]   n_cur, n_cap, idx_cur, weight;
  logic [S0_W-1:0]    s0_cur;
  logic [S1_W-1:0]    s1_cur, wprod;

  always_comb begin
    n_cur      = start_i ? num_reads_i : n_q;
    idx_cur    = start_i ? '0 : idx_q;
    s0_cur     = start_i ? '0 : s0_q;
    s1_cur     = start_i ? '0 : s1_q;
    over_cur   = start_i ? 1'b0 : over_q;
    live       = start_i | active_q;
    n_cap      = (n_cur > CAP) ? CAP : n_cur;
    take       = sample_valid_i & live;
    accept     = take & (idx_cur < n_cap);
    weight     = idx_cur + CNT_W'(1);
    wprod      = S1_W'(sample_i) * S1_W'(weight);
    close_ramp = end_i & active_q & ~start_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      over_q   <= 1'b0;
      n_q      <= '0;
      idx_q    <= '0;
      s0_q     <= '0;
      s1_q     <= '0;
      recip_q  <= '0;
    end else begin
      done_q <= close_ramp;
      if (start_i) begin
        active_q <= 1'b1;
        n_q      <= num_reads_i;
        recip_q  <= recip_i;
      end else if (close_ramp) begin
        active_q <= 1'b0;
      end
      idx_q  <= idx_cur + CNT_W'(accept);
      s0_q   <= s0_cur + (accept ? S0_W'(sample_i) : '0);
      s1_q   <= s1_cur + (accept ? wprod : '0);
      over_q <= over_cur | (take & ~accept);
    end
  end

  assign done_o  = done_q;
  assign s0_o    = s0_q;
  assign s1_o    = s1_q;
  assign n_o     = n_q;
  assign cnt_o   = idx_q;
  assign over_o  = over_q;
  assign recip_o = recip_q;

  p_start_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !sample_valid_i |=> (idx_q == '0) && (s0_q == '0) && (s1_q == '0));

  p_idle_ignore_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q && !start_i |=> $stable(s0_q) && $stable(s1_q) && $stable(idx_q));

  p_idx_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= CAP);
endmodule

// File: rtl/ramp_combine.sv
module ramp_combine
  import ramp_fit_pkg::*;
#(
  parameter int MAX_READS = 256,
  parameter int RECIP_W   = 24,
  parameter int CNT_W     = 9,
  parameter int S0_W      = 25,
  parameter int S1_W      = 34,
  parameter int NUM_W     = 39
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    done_i,
  input  logic [S0_W-1:0]         s0_i,
  input  logic [S1_W-1:0]         s1_i,
  input  logic [CNT_W-1:0]        n_i,
  input  logic [CNT_W-1:0]        cnt_i,
  input  logic                    over_i,
  input  logic [RECIP_W-1:0]      recip_i,
  output logic                    v_o,
  output logic                    err_o,
  output logic signed [NUM_W-1:0] num_o,
  output logic [RECIP_W-1:0]      recip_o
);
  logic               n_bad;
  logic [NUM_W-1:0]   s1_term, s0_term, n_plus;
  logic               v_q, err_q;
  logic [NUM_W-1:0]   num_q;
  logic [RECIP_W-1:0] recip_q;

  always_comb begin
    n_bad   = (n_i < CNT_W'(MIN_READS)) | (32'(n_i) > 32'(MAX_READS));
    n_plus  = NUM_W'(n_i) + NUM_W'(1);
    s1_term = NUM_W'(s1_i) * NUM_W'(S1_WEIGHT);
    s0_term = NUM_W'(s0_i) * n_plus * NUM_W'(S0_WEIGHT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q     <= 1'b0;
      err_q   <= 1'b0;
      num_q   <= '0;
      recip_q <= '0;
    end else begin
      v_q <= done_i;
      if (done_i) begin
        err_q   <= n_bad | (cnt_i != n_i) | over_i;
        num_q   <= n_bad ? '0 : (s1_term - s0_term);
        recip_q <= recip_i;
      end
    end
  end

  assign v_o     = v_q;
  assign err_o   = err_q;
  assign num_o   = signed'(num_q);
  assign recip_o = recip_q;

  p_bad_n_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && (n_i < CNT_W'(MIN_READS)) |=> v_q && err_q && (num_q == '0));

  p_short_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && (cnt_i != n_i) |=> err_q);
endmodule

// File: rtl/ramp_scale.sv
module ramp_scale #(
  parameter int RECIP_W = 24,
  parameter int FRAC_W  = 24,
  parameter int NUM_W   = 39
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    v_i,
  input  logic                    err_i,
  input  logic signed [NUM_W-1:0] num_i,
  input  logic [RECIP_W-1:0]      recip_i,
  output logic                    valid_o,
  output logic                    err_o,
  output logic signed [NUM_W-1:0] num_o,
  output logic signed [NUM_W-1:0] slope_o
);
  localparam int PROD_W = NUM_W + RECIP_W + 1;

  logic signed [PROD_W-1:0] prod;
  logic signed [NUM_W-1:0]  slope_d;

  assign prod = PROD_W'(num_i) * signed'(PROD_W'({1'b0, recip_i}));

  generate
    if (FRAC_W > 0) begin : g_shift
      assign slope_d = NUM_W'(prod >>> FRAC_W);
    end else begin : g_noshift
      assign slope_d = NUM_W'(prod);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      num_o   <= '0;
      slope_o <= '0;
    end else begin
      valid_o <= v_i;
      if (v_i) begin
        err_o   <= err_i;
        num_o   <= num_i;
        slope_o <= slope_d;
      end
    end
  end

  p_valid_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !v_i |=> $stable(num_o) && $stable(slope_o) && $stable(err_o));
endmodule

// File: rtl/ramp_slope_fit.sv
module ramp_slope_fit #(
  parameter int SAMPLE_W  = 16,
  parameter int MAX_READS = 256,
  parameter int RECIP_W   = 24,
  parameter int FRAC_W    = 24,
  localparam int CNT_W    = $clog2(MAX_READS + 1),
  localparam int NUM_W    = SAMPLE_W + 2 * CNT_W + 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    end_i,
  input  logic                    sample_valid_i,
  input  logic [SAMPLE_W-1:0]     sample_i,
  input  logic [CNT_W-1:0]        num_reads_i,
  input  logic [RECIP_W-1:0]      recip_i,
  output logic                    valid_o,
  output logic                    err_o,
  output logic signed [NUM_W-1:0] slope_num_o,
  output logic signed [NUM_W-1:0] slope_o
);
  localparam int S0_W = SAMPLE_W + CNT_W;
  localparam int S1_W = SAMPLE_W + 2 * CNT_W;

  logic                    done, over, c_v, c_err;
  logic [S0_W-1:0]         s0;
  logic [S1_W-1:0]         s1;
  logic [CNT_W-1:0]        n_lat, cnt;
  logic [RECIP_W-1:0]      recip_a, recip_c;
  logic signed [NUM_W-1:0] c_num;

  ramp_accum #(
    .SAMPLE_W(SAMPLE_W), .MAX_READS(MAX_READS), .RECIP_W(RECIP_W),
    .CNT_W(CNT_W), .S0_W(S0_W), .S1_W(S1_W)
  ) u_accum (
    .clk_i, .rst_ni, .start_i, .end_i, .sample_valid_i, .sample_i,
    .num_reads_i, .recip_i,
    .done_o(done), .s0_o(s0), .s1_o(s1), .n_o(n_lat), .cnt_o(cnt),
    .over_o(over), .recip_o(recip_a)
  );

  ramp_combine #(
    .MAX_READS(MAX_READS), .RECIP_W(RECIP_W), .CNT_W(CNT_W),
    .S0_W(S0_W), .S1_W(S1_W), .NUM_W(NUM_W)
  ) u_combine (
    .clk_i, .rst_ni, .done_i(done), .s0_i(s0), .s1_i(s1), .n_i(n_lat),
    .cnt_i(cnt), .over_i(over), .recip_i(recip_a),
    .v_o(c_v), .err_o(c_err), .num_o(c_num), .recip_o(recip_c)
  );

  ramp_scale #(
    .RECIP_W(RECIP_W), .FRAC_W(FRAC_W), .NUM_W(NUM_W)
  ) u_scale (
    .clk_i, .rst_ni, .v_i(c_v), .err_i(c_err), .num_i(c_num), .recip_i(recip_c),
    .valid_o, .err_o, .num_o(slope_num_o), .slope_o
  );
endmodule

// File: tb/ramp_slope_fit_test.sv
module ramp_slope_fit_test;
  localparam int MR = 256;
  localparam int FW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic start = 0, endm = 0, sv = 0;
  logic [15:0] smp = '0;
  logic [8:0]  nr = '0;
  logic [23:0] rc = '0;
  logic valid, err;
  logic signed [38:0] num, slope;

  ramp_slope_fit #(.SAMPLE_W(16), .MAX_READS(MR), .RECIP_W(24), .FRAC_W(FW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .end_i(endm),
    .sample_valid_i(sv), .sample_i(smp), .num_reads_i(nr), .recip_i(rc),
    .valid_o(valid), .err_o(err), .slope_num_o(num), .slope_o(slope)
  );

  int vectors = 0, fails = 0;

  // behavioural reference
  bit m_active, m_over, m_close;
  int m_n, m_idx, ncur, ncap, icur;
  longint m_rc, m_s0, m_s1, s0c, s1c;
  bit oc, bad;
  bit p1_v, p2_v, e_v, p1_err, p2_err, e_err;
  longint p1_num, p2_num, e_num, p1_sl, p2_sl, e_sl;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_active = 0; m_over = 0; m_n = 0; m_idx = 0; m_rc = 0; m_s0 = 0; m_s1 = 0;
      p1_v = 0; p2_v = 0; e_v = 0; p1_err = 0; p2_err = 0; e_err = 0;
      p1_num = 0; p2_num = 0; e_num = 0; p1_sl = 0; p2_sl = 0; e_sl = 0;
    end else begin
      if (p2_v) begin e_num = p2_num; e_sl = p2_sl; e_err = p2_err; end
      e_v = p2_v;
      p2_v = p1_v; p2_num = p1_num; p2_sl = p1_sl; p2_err = p1_err;
      p1_v = 0;
      m_close = endm && m_active && !start;
      if (start) begin
        ncur = int'(nr); icur = 0; s0c = 0; s1c = 0; oc = 0; m_rc = longint'(rc);
      end else begin
        ncur = m_n; icur = m_idx; s0c = m_s0; s1c = m_s1; oc = m_over;
      end
      ncap = (ncur > MR) ? MR : ncur;
      if (sv && (start || m_active)) begin
        if (icur < ncap) begin
          icur++;
          s0c += longint'(smp);
          s1c += longint'(icur) * longint'(smp);
        end else oc = 1;
      end
      m_n = ncur; m_idx = icur; m_s0 = s0c; m_s1 = s1c; m_over = oc;
      if (start) m_active = 1;
      else if (m_close) m_active = 0;
      if (m_close) begin
        bad = (m_n < 2) || (m_n > MR);
        p1_v = 1;
        p1_err = bad || (m_idx != m_n) || m_over;
        p1_num = bad ? 0 : 12 * m_s1 - 6 * longint'(m_n + 1) * m_s0;
        p1_sl = (p1_num * m_rc) >>> FW;
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      vectors++;
      if (valid !== e_v) begin
        fails++; $display("FAIL R5 valid_o actual %0b expected %0b", valid, e_v);
      end
      if (err !== e_err) begin
        fails++; $display("FAIL R6/R7/R8 err_o actual %0b expected %0b", err, e_err);
      end
      if (longint'(num) != e_num) begin
        fails++; $display("FAIL R3 slope_num_o actual %0d expected %0d", num, e_num);
      end
      if (longint'(slope) != e_sl) begin
        fails++; $display("FAIL R4 slope_o actual %0d expected %0d", slope, e_sl);
      end
    end
  end

  int cap_cnt = 0;
  longint cap_num = 0, cap_sl = 0;
  bit cap_err = 0;
  always @(negedge clk) begin
    if (rst_n && valid) begin
      cap_cnt++; cap_num = longint'(num); cap_sl = longint'(slope); cap_err = err;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      fails++; $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic ramp(input int n, input int r, input int cnt, input int base,
                      input int step, input bit first_with_start,
                      input bit end_with_last, input bit gaps);
    cap_cnt = 0;
    @(negedge clk);
    start = 1; nr = 9'(n); rc = 24'(r); sv = 0; endm = 0;
    if (first_with_start) begin sv = 1; smp = 16'(base); end
    for (int k = (first_with_start ? 2 : 1); k <= cnt; k++) begin
      @(negedge clk);
      start = 0;
      if (gaps) begin sv = 0; @(negedge clk); end
      sv = 1; smp = 16'(base + step * (k - 1));
      endm = end_with_last && (k == cnt);
    end
    @(negedge clk);
    start = 0; sv = 0; endm = !end_with_last;
    @(negedge clk);
    endm = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R5 watchdog actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid_o", longint'(valid), 0);
    chk("R1 err_o", longint'(err), 0);
    chk("R1 slope_num_o", longint'(num), 0);
    chk("R1 slope_o", longint'(slope), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R3 R4 two reads 10,30
    ramp(2, 2796203, 2, 10, 20, 0, 0, 0);
    chk("R5 one result", cap_cnt, 1);
    chk("R3 n=2 numerator", cap_num, 120);
    chk("R4 n=2 slope", cap_sl, 20);
    chk("R3 n=2 err", longint'(cap_err), 0);

    // R3 gaps, last read with end, slope 7
    ramp(5, 139811, 5, 100, 7, 0, 1, 1);
    chk("R3 gapped numerator", cap_num, 840);
    chk("R4 gapped slope", cap_sl, 7);

    // R10 R2 full-scale flat ramp, first read with start
    ramp(256, 1, 256, 65535, 0, 1, 0, 0);
    chk("R10 flat full scale numerator", cap_num, 0);
    chk("R2 flat err", longint'(cap_err), 0);

    // R10 R4 steep falling ramp
    ramp(256, 1, 256, 65535, -255, 0, 0, 0);
    chk("R10 falling numerator", cap_num, -64'sd4278124800);
    chk("R4 falling slope floor", cap_sl, -255);

    // R6 bad n
    ramp(1, 1, 1, 500, 0, 0, 0, 0);
    chk("R6 n=1 err", longint'(cap_err), 1);
    chk("R6 n=1 numerator", cap_num, 0);
    ramp(300, 1, 3, 5, 5, 0, 0, 0);
    chk("R6 n=300 err", longint'(cap_err), 1);
    chk("R6 n=300 slope", cap_sl, 0);

    // R7 short ramp
    ramp(4, 1, 3, 10, 10, 0, 0, 0);
    chk("R7 short err", longint'(cap_err), 1);
    chk("R7 short numerator", cap_num, -120);

    // R8 extra reads ignored
    ramp(3, 1, 5, 10, 10, 0, 0, 0);
    chk("R8 extra err", longint'(cap_err), 1);
    chk("R8 extra numerator", cap_num, 240);

    // R9 activity with no open ramp
    cap_cnt = 0;
    @(negedge clk); sv = 1; smp = 16'd999;
    repeat (3) @(negedge clk);
    endm = 1; @(negedge clk); endm = 0; sv = 0;
    repeat (4) @(negedge clk);
    chk("R9 idle end no result", cap_cnt, 0);
    ramp(2, 2796203, 2, 10, 20, 0, 0, 0);
    chk("R9 next ramp numerator", cap_num, 120);

    // R2 restart discards an open ramp
    @(negedge clk); start = 1; nr = 9'd3; rc = 24'd1; sv = 1; smp = 16'd500;
    @(negedge clk); start = 0; smp = 16'd600;
    @(negedge clk); sv = 0;
    ramp(3, 1, 3, 10, 10, 0, 0, 0);
    chk("R2 restart one result", cap_cnt, 1);
    chk("R2 restart numerator", cap_num, 240);
    chk("R2 restart err", longint'(cap_err), 0);

    summary();
    $finish;
  end
endmodule